// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

The block gathers eight interrupt request lines into one interrupt signal for a CPU. It returns an 8-bit vector when the CPU acknowledges. Software reaches it through two byte-wide addresses, a command port and a data port, selected by one address bit and qualified by read and write strobes.

A command write with bit 4 set starts configuration. The data writes that follow are taken as configuration words, in this order:

- the vector base;
- a cascade word, only when cascade mode was selected;
- a mode word, only when it was asked for.

Once the sequence ends, data writes load the interrupt mask. Requests are edge triggered. Input 0 has the highest priority and the priority order is fixed. An in-service register records the lines being handled. A non-specific end-of-interrupt command releases the line with the highest priority among them.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, int_out and vec_valid are 0, the mask is 0x00, the in-service register is 0x00, and the controller is unconfigured.
- R2: A command-port write with bit 4 set restarts configuration and clears all pending and in-service bits. While configuration is incomplete, int_out stays 0 and request edges are not latched.
- R3: Data-port writes are consumed in this order. The first is the base word. The cascade word follows only if the restart word had bit 1 = 0. The mode word follows only if the restart word had bit 0 = 1. Any later data write is a mask write.
- R4: The vector returned is {base[7:3], line index[2:0]}. The low three bits of the base word are dropped.
- R5: When configured, a data write loads the mask and a data read returns it. A mask bit of 1 keeps its line from raising int_out, but a latched request stays pending. Clearing the mask bit then raises int_out.
- R6: A restart leaves the mask unchanged.
- R7: A request is latched on a rising edge of its synchronized input. A line held high after its acknowledge does not request again.
- R8: int_out and the acknowledged vector select the lowest-numbered unmasked pending line. Each acknowledge sets at most one in-service bit.
- R9: int_out is 1 only if the selected line has a lower index than every set in-service bit.
- R10: A command write of exactly 0x20 clears the lowest-numbered set in-service bit. Any other command write with bit 4 = 0 leaves the in-service register unchanged.
- R11: When the mode word has bit 1 = 1 (automatic end-of-interrupt), an acknowledge sets no in-service bit.
- R12: A command-port read returns the in-service register.
- R13: ack while int_out is 0 has no effect. vec_valid pulses for one cycle only after an ack taken while int_out was 1, and vec_out holds the vector during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | 0 selects the command port, 1 selects the data port |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, which is the mask from the data port or the in-service register from the command port; 0 when rd_en is low |
| irq_in | input | 8 | Interrupt request lines, asynchronous |
| int_out | output | 1 | Interrupt to the CPU |
| ack | input | 1 | Interrupt acknowledge from the CPU |
| vec_out | output | 8 | Vector of the acknowledged line |
| vec_valid | output | 1 | One-cycle strobe marking vec_out |

## Verification
The assertions assume four things about the inputs:

- ack is a short pulse issued only in response to int_out, or as a deliberate stray pulse.
- Register writes and acknowledges never fall in the same cycle.
- Request lines change slowly compared with the two-stage synchronizer.
- Configuration words arrive only on the data port.

The stimulus keeps within these rules. It drives writes and acknowledges one at a time from tasks, on the falling clock edge. It holds each request line steady for several cycles before it samples int_out. A stray acknowledge is sent only when no request can be granted.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int BYTE_W = 8;
    localparam int BASE_W = BYTE_W - IDX_W;
    localparam logic [BYTE_W-1:0] EOI_CODE = 8'h20;
    localparam int RESTART_BIT = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_BASE,
        SQ_CASC,
        SQ_MODE,
        SQ_RUN
    } seq_state_t;

    typedef struct packed {
        logic [BASE_W-1:0] base_hi;
        logic              single;
        logic              want_mode;
        logic              auto_eoi;
        logic [BYTE_W-1:0] cascade;
    } pic_cfg_t;

    // index of lowest set bit, LINES when none is set
    function automatic logic [IDX_W:0] first_set(input logic [LINES-1:0] v);
        logic [IDX_W:0] r;
        r = (IDX_W+1)'(LINES);
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) r = (IDX_W+1)'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              ready,
    output logic              mask_wr,
    output pic_cfg_t          cfg
);
    seq_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cfg   <= '0;
        end else if (restart) begin
            state         <= SQ_BASE;
            cfg.want_mode <= wdata[0];
            cfg.single    <= wdata[1];
            cfg.auto_eoi  <= 1'b0;
        end else if (data_wr) begin
            case (state)
                SQ_BASE: begin
                    cfg.base_hi <= wdata[BYTE_W-1:IDX_W];
                    if (!cfg.single)       state <= SQ_CASC;
                    else if (cfg.want_mode) state <= SQ_MODE;
                    else                    state <= SQ_RUN;
                end
                SQ_CASC: begin
                    cfg.cascade <= wdata;
                    state <= cfg.want_mode ? SQ_MODE : SQ_RUN;
                end
                SQ_MODE: begin
                    cfg.auto_eoi <= wdata[1];
                    state <= SQ_RUN;
                end
                default: ;
            endcase
        end
    end

    assign ready   = (state == SQ_RUN);
    assign mask_wr = data_wr && ready;
endmodule

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
    parameter int N           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise
);
    logic [N-1:0] stage [SYNC_STAGES];
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
            prev <= '0;
        end else begin
            stage[0] <= lines;
            for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
            prev <= stage[SYNC_STAGES-1];
        end
    end

    assign rise = stage[SYNC_STAGES-1] & ~prev;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  logic             ready,
    input  logic [LINES-1:0] irr,
    input  logic [LINES-1:0] imr,
    input  logic [LINES-1:0] isr,
    output logic             grant,
    output logic [IDX_W:0]   win_idx,
    output logic [IDX_W:0]   top_idx
);
    assign win_idx = first_set(irr & ~imr);
    assign top_idx = first_set(isr);
    // win_idx below top_idx also implies a pending line exists
    assign grant   = ready && (win_idx < top_idx);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import pic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [LINES-1:0]  irq_in,
    output logic              int_out,
    input  logic              ack,
    output logic [BYTE_W-1:0] vec_out,
    output logic              vec_valid
);
    logic             cmd_wr, data_wr, restart, eoi_hit, ack_take;
    logic             ready, mask_wr;
    pic_cfg_t         cfg;
    logic [LINES-1:0] rise, irr, imr, isr;
    logic [IDX_W:0]   win_idx, top_idx;
    logic [LINES-1:0] win_bit, top_bit;
    logic             unused_cfg;

    assign cmd_wr   = wr_en && !addr_sel;
    assign data_wr  = wr_en && addr_sel;
    assign restart  = cmd_wr && wdata[RESTART_BIT];
    assign eoi_hit  = cmd_wr && (wdata == EOI_CODE);
    assign ack_take = ack && int_out;

    pic_init_seq u_seq (
        .clk(clk), .rst(rst), .restart(restart), .data_wr(data_wr),
        .wdata(wdata), .ready(ready), .mask_wr(mask_wr), .cfg(cfg)
    );

    pic_edge_latch #(.N(LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .lines(irq_in), .rise(rise)
    );

    pic_resolver u_res (
        .ready(ready), .irr(irr), .imr(imr), .isr(isr),
        .grant(int_out), .win_idx(win_idx), .top_idx(top_idx)
    );

    assign win_bit = ack_take ? (LINES'(1) << win_idx[IDX_W-1:0]) : '0;
    assign top_bit = (eoi_hit && !top_idx[IDX_W]) ? (LINES'(1) << top_idx[IDX_W-1:0]) : '0;

    always_ff @(posedge clk) begin
        if (rst) imr <= '0;
        else if (mask_wr) imr <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= (irr | (ready ? rise : '0)) & ~win_bit;
            isr <= (isr & ~top_bit) | (cfg.auto_eoi ? '0 : win_bit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= ack_take;
            if (ack_take) vec_out <= {cfg.base_hi, win_idx[IDX_W-1:0]};
        end
    end

    assign rdata = rd_en ? (addr_sel ? imr : isr) : '0;

    assign unused_cfg = ^cfg.cascade;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              int_out,
    input logic              ack,
    input logic              vec_valid,
    input logic [BYTE_W-1:0] vec_out,
    input logic [BASE_W-1:0] base_hi,
    input logic              auto_eoi,
    input logic [LINES-1:0]  irr,
    input logic [LINES-1:0]  imr,
    input logic [LINES-1:0]  isr
);
    AST_QUIET_UNCONFIGURED: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !int_out); // R2
    AST_INT_HAS_PENDING: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr) != '0)); // R5
    AST_VEC_FROM_BASE: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out[BYTE_W-1:IDX_W] == base_hi)); // R4
    AST_ONE_SERVICE_SET: assert property (@(posedge clk) disable iff (rst)
        $countones(isr & ~$past(isr)) <= 1); // R8
    AST_AUTO_EOI_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (ready && auto_eoi) |-> (isr == '0)); // R11
    AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack && int_out)); // R13
endmodule

bind irq_ctrl pic_checker u_chk (
    .clk(clk), .rst(rst), .ready(ready), .int_out(int_out), .ack(ack),
    .vec_valid(vec_valid), .vec_out(vec_out), .base_hi(cfg.base_hi),
    .auto_eoi(cfg.auto_eoi), .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, irq_in = '0;
    logic [7:0] rdata, vec_out;
    logic       int_out, vec_valid;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q [$];

    irq_ctrl uut (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
        .ack(ack), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        addr_sel = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        @(negedge clk);
        addr_sel = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic ack_pulse(bit expect_vec, logic [7:0] v);
        @(negedge clk);
        if (expect_vec) exp_q.push_back(v);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // monitor: pops expected vectors as the design produces them
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R13 unexpected vector actual=%h expected=none", vec_out);
            end else begin
                check("R4 R8 vector", vec_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R1 int_out", {7'd0, int_out}, 8'h00);
        check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        rd(1'b0, r); check("R1 isr", r, 8'h00);
        rd(1'b1, r); check("R1 mask", r, 8'h00);

        // unconfigured: no interrupt
        irq_in[3] = 1'b1; cyc(6);
        check("R2 quiet before config", {7'd0, int_out}, 8'h00);
        irq_in[3] = 1'b0; cyc(4);

        // full four-word configuration, cascade mode
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        rd(1'b1, r); check("R3 words not taken as mask", r, 8'h00);
        wr(1'b1, 8'h08);
        rd(1'b1, r); check("R5 mask readback", r, 8'h08);

        irq_in[3] = 1'b1; cyc(6);
        check("R5 masked line blocked", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h00);
        check("R5 unmask raises pending", {7'd0, int_out}, 8'h01);
        ack_pulse(1, 8'h23);
        cyc(1);
        check("R9 served line quiet", {7'd0, int_out}, 8'h00);
        rd(1'b0, r); check("R12 isr after ack", r, 8'h08);
        cyc(6);
        check("R7 held line no new request", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h20);
        rd(1'b0, r); check("R10 eoi clears", r, 8'h00);
        check("R7 no request after eoi", {7'd0, int_out}, 8'h00);
        irq_in = '0; cyc(4);

        // priority
        irq_in[5] = 1'b1; irq_in[1] = 1'b1; cyc(6);
        ack_pulse(1, 8'h21);
        cyc(1);
        check("R9 lower line held off", {7'd0, int_out}, 8'h00);
        irq_in[0] = 1'b1; cyc(6);
        check("R9 higher line preempts", {7'd0, int_out}, 8'h01);
        ack_pulse(1, 8'h20);
        rd(1'b0, r); check("R8 isr two levels", r, 8'h03);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); check("R10 other command ignored", r, 8'h03);
        wr(1'b0, 8'h20);
        rd(1'b0, r); check("R10 eoi clears highest", r, 8'h02);
        check("R9 still held off", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h20);
        check("R9 eoi releases lower", {7'd0, int_out}, 8'h01);
        ack_pulse(1, 8'h25);
        wr(1'b0, 8'h20);
        irq_in = '0; cyc(4);

        // stray ack
        ack_pulse(0, 8'h00);
        check("R13 stray ack no vector", {7'd0, vec_valid}, 8'h00);
        rd(1'b0, r); check("R13 stray ack no isr", r, 8'h00);

        // restart in single mode without mode word
        wr(1'b1, 8'h40);
        irq_in[2] = 1'b1; cyc(6);
        wr(1'b0, 8'h12);
        check("R2 restart quiet", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h48);
        rd(1'b1, r); check("R6 mask kept over restart", r, 8'h40);
        check("R2 pending cleared by restart", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h00);
        rd(1'b1, r); check("R3 single short sequence", r, 8'h00);
        irq_in[6] = 1'b1; cyc(6);
        ack_pulse(1, 8'h4E);
        wr(1'b0, 8'h20);
        irq_in = '0; cyc(4);

        // automatic end-of-interrupt, base low bits dropped
        wr(1'b0, 8'h13); wr(1'b1, 8'h8B); wr(1'b1, 8'h03);
        irq_in[4] = 1'b1; cyc(6);
        ack_pulse(1, 8'h8C);
        rd(1'b0, r); check("R11 auto eoi no isr", r, 8'h00);
        irq_in[7] = 1'b1; cyc(6);
        check("R11 next line not blocked", {7'd0, int_out}, 8'h01);
        ack_pulse(1, 8'h8F);
        cyc(3);
        check("R8 all vectors seen", 8'(exp_q.size()), 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule